// File: doc/BRIEF.md
# Latched 24-bit Serial Register Interface

This block is a three-wire serial slave that lets a host configure a bank of 16-bit registers. The host lowers the latch input, clocks a 24-bit frame in most significant bit first on rising edges of the serial clock, and then raises the latch. That rising latch edge decides what happens. A write frame copies its 16 data bits into the addressed register. A read frame arms a readback: the addressed register's 16 bits then appear, most significant first, on a shared output pin while the host clocks its next frame.

The serial inputs are sampled by the block's own system clock through short synchronizer chains, so the serial clock must be several times slower than the system clock. Every register leaves reset at a value derived from its address. A soft-reset bit in register 0 restores all of those values and clears itself. Register 1 chooses what the shared pin carries: serial readback data, or a gated lock indicator. Any write to address 0 also produces a one-cycle kick pulse, which other logic uses to restart calibration or the modulator.

Top module: `serial_regbank`

## Requirements
- R1: A frame is 24 bits shifted MSB first on rising serial-clock edges while latch is low: bit 23 is the direction flag (0 = write, 1 = read), bits 22:16 the register address, bits 15:0 the data. Serial clocks seen while latch is high do not shift.
- R2: On the rising latch edge, a write frame stores its data field into the addressed register, and a later readback of that address returns it.
- R3: After rst_n is released, register a holds 16'h5000 XOR (a << 5); register 1 therefore has bits 1:0 = 0.
- R4: Writing address 0 with data bit 0 set restores every register to its R3 value, and bit 0 of register 0 then reads back 0.
- R5: After a read frame latches, the shared pin (when readback is selected) shows data bit 15 at once and bit 15-k after the k-th falling serial-clock edge of the following frame. A read frame changes no register.
- R6: With register 1 bit 1 = 0, the shared pin equals the lock input when register 1 bit 0 = 1, and is low when bit 0 = 0. With register 1 bit 1 = 1, the pin carries readback data.
- R7: A frame of more or fewer than 24 clocks is decoded from the last 24 bits shifted in, which can include bits left from earlier frames.
- R8: Each write frame to address 0 produces exactly one single-cycle pulse on cal_kick. Writes to other addresses and all read frames produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data in |
| ser_le | input | 1 | Latch enable; low while shifting, rising edge commits |
| pll_lock | input | 1 | Lock status to be presented on the shared pin |
| mux_pin | output | 1 | Shared pin: lock indication or readback data |
| cal_kick | output | 1 | One-cycle pulse on every write to address 0 |

## Verification
The bench uses the default parameters: 7 address bits, 16 data bits, all 128 registers, and two synchronizer stages. The serial half-period is six system clocks. With these values the whole address range, including the top address 127, is reachable for random writes and readbacks. The reset value of every address follows from its index, so power-on values can be checked at the bottom, the middle and the top of the map. Odd-length frames are set up so that their decoded command depends on bits left over from the previous frame.

// File: rtl/serial_regbank.sv
module serial_regbank #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int NUM_REGS    = 128,
  parameter int SYNC_STAGES = 2,
  parameter int PINCFG_ADDR = 1,
  parameter int POR_SHIFT   = 5,
  parameter logic [DATA_W-1:0] POR_BASE = 'h5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_dat,
  input  logic ser_le,
  input  logic pll_lock,
  output logic mux_pin,
  output logic cal_kick
);
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;
  localparam logic [ADDR_W-1:0] PIN_IDX = ADDR_W'(PINCFG_ADDR);

  function automatic logic [DATA_W-1:0] por_val(input int a);
    por_val = POR_BASE ^ DATA_W'(a << POR_SHIFT);
  endfunction

  logic [SYNC_STAGES:0]   sck_q, le_q;
  logic [SYNC_STAGES-1:0] sdi_q;
  logic [FRAME_W-1:0]     shift_q;
  logic [DATA_W-1:0]      regs [NUM_REGS];
  logic [DATA_W-1:0]      rb_q, rd_word;
  logic                   kick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      le_q  <= '1;
      sdi_q <= '0;
    end else begin
      sck_q <= {sck_q[SYNC_STAGES-1:0], ser_clk};
      le_q  <= {le_q[SYNC_STAGES-1:0], ser_le};
      sdi_q <= {sdi_q[SYNC_STAGES-2:0], ser_dat};
    end
  end

  wire sck_s    = sck_q[SYNC_STAGES-1];
  wire sck_rise = sck_s & ~sck_q[SYNC_STAGES];
  wire sck_fall = ~sck_s & sck_q[SYNC_STAGES];
  wire le_s     = le_q[SYNC_STAGES-1];
  wire commit   = le_s & ~le_q[SYNC_STAGES];

  wire                is_rd   = shift_q[FRAME_W-1];
  wire [ADDR_W-1:0]   fr_addr = shift_q[FRAME_W-2:DATA_W];
  wire [DATA_W-1:0]   fr_data = shift_q[DATA_W-1:0];
  wire                in_map  = int'(fr_addr) < NUM_REGS;
  wire                wr_en   = commit & ~is_rd;
  wire                soft_rst = wr_en && (fr_addr == '0) && fr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    shift_q <= '0;
    else if (sck_rise && !le_s)    shift_q <= {shift_q[FRAME_W-2:0], sdi_q[SYNC_STAGES-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= por_val(i);
    end else if (soft_rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= por_val(i);
    end else if (wr_en && in_map) begin
      regs[fr_addr] <= fr_data;
    end
  end

  assign rd_word = in_map ? regs[fr_addr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_q   <= '0;
      kick_q <= 1'b0;
    end else begin
      kick_q <= wr_en && (fr_addr == '0);
      if (commit)        rb_q <= is_rd ? rd_word : '0;
      else if (sck_fall) rb_q <= {rb_q[DATA_W-2:0], 1'b0};
    end
  end

  wire ld_en  = regs[PIN_IDX][0];
  wire rb_sel = regs[PIN_IDX][1];

  assign mux_pin  = rb_sel ? rb_q[DATA_W-1] : (ld_en & pll_lock);
  assign cal_kick = kick_q;
endmodule

// File: rtl/serial_regbank_chk.sv
module serial_regbank_chk #(
  parameter int DATA_W  = 16,
  parameter int FRAME_W = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cal_kick,
  input logic               mux_pin,
  input logic               le_s,
  input logic               sck_fall,
  input logic               commit,
  input logic               rb_sel,
  input logic               ld_en,
  input logic               reg0_lsb,
  input logic [FRAME_W-1:0] shift_q,
  input logic [DATA_W-1:0]  rb_q
);
  a_r1_no_shift_latched: assert property (@(posedge clk) disable iff (!rst_n)
    le_s |=> $stable(shift_q));

  a_r8_kick_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cal_kick |=> !cal_kick);

  a_r4_soft_bit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cal_kick |-> !reg0_lsb);

  a_r5_readback_shifts: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall && !commit) |=> rb_q == {$past(rb_q[DATA_W-2:0]), 1'b0});

  a_r6_lock_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!rb_sel && !ld_en) |-> !mux_pin);
endmodule

bind serial_regbank serial_regbank_chk #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cal_kick(cal_kick), .mux_pin(mux_pin),
  .le_s(le_s), .sck_fall(sck_fall), .commit(commit), .rb_sel(rb_sel),
  .ld_en(ld_en), .reg0_lsb(regs[0][0]), .shift_q(shift_q), .rb_q(rb_q)
);

// File: tb/test_serial_regbank.sv
module test_serial_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk, ser_dat, ser_le, pll_lock;
  logic mux_pin, cal_kick;

  serial_regbank i_serial_regbank (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_le(ser_le), .pll_lock(pll_lock), .mux_pin(mux_pin), .cal_kick(cal_kick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, kick_cnt = 0, exp_kick = 0;
  bit done = 0;
  logic [15:0] model [128];
  logic [23:0] tb_sr = '0;
  logic [31:0] cap;

  always @(posedge clk) if (rst_n && cal_kick) kick_cnt++;

  function automatic logic [15:0] por(input int a);
    por = 16'h5000 ^ 16'(a << 5);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply_frame();
    logic [6:0] a;
    a = tb_sr[22:16];
    if (!tb_sr[23]) begin
      if (a == 0) exp_kick++;
      if (a == 0 && tb_sr[0]) begin
        for (int i = 0; i < 128; i++) model[i] = por(i);
      end else model[a] = tb_sr[15:0];
    end
  endtask

  task automatic send(input logic [31:0] v, input int n);
    ser_le = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic b;
      b = v[n-1-i];
      ser_dat = b;
      repeat (HALF) @(posedge clk);
      #1;
      if (i < 32) cap[i] = mux_pin;
      tb_sr = {tb_sr[22:0], b};
      ser_clk = 1'b1;
      repeat (HALF) @(posedge clk);
      #1 ser_clk = 1'b0;
    end
    repeat (HALF) @(posedge clk);
    #1 ser_le = 1'b1;
    repeat (2*HALF) @(posedge clk);
    #1;
    apply_frame();
  endtask

  task automatic collect(output logic [15:0] val);
    send(32'h0080_0000, 24);
    for (int i = 0; i < 16; i++) val[15-i] = cap[i];
  endtask

  task automatic read_reg(input logic [6:0] a, output logic [15:0] val);
    send({8'h0, 1'b1, a, 16'h0}, 24);
    collect(val);
  endtask

  task automatic write_reg(input logic [6:0] a, input logic [15:0] d);
    send({8'h0, 1'b0, a, d}, 24);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [6:0] a;
    void'($urandom(32'd2718));
    for (int i = 0; i < 128; i++) model[i] = por(i);
    ser_clk = 0; ser_dat = 0; ser_le = 1; pll_lock = 1;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R3 pin low at reset", mux_pin, 0);
    chk("R8 no kick at reset", kick_cnt, 0);

    write_reg(7'd1, 16'h0001);
    pll_lock = 1; repeat (3) @(posedge clk); #1;
    chk("R6 lock high", mux_pin, 1);
    pll_lock = 0; repeat (3) @(posedge clk); #1;
    chk("R6 lock low", mux_pin, 0);
    write_reg(7'd1, 16'h0000);
    pll_lock = 1; repeat (3) @(posedge clk); #1;
    chk("R6 lock gated off", mux_pin, 0);
    chk("R8 no kick other addr", kick_cnt, exp_kick);

    write_reg(7'd1, 16'h0002);
    read_reg(7'd2, v);   chk("R3 por addr 2", v, por(2));
    read_reg(7'd77, v);  chk("R3 por addr 77", v, por(77));
    read_reg(7'd127, v); chk("R3 por addr 127", v, por(127));
    read_reg(7'd1, v);   chk("R2 readback pin cfg", v, 16'h0002);
    chk("R8 reads make no kick", kick_cnt, exp_kick);

    for (int k = 0; k < 30; k++) begin
      a = 7'(2 + ($urandom % 126));
      write_reg(a, 16'($urandom));
    end
    for (int k = 0; k < 12; k++) begin
      a = 7'(2 + ($urandom % 126));
      read_reg(a, v);
      chk($sformatf("R2 R1 random readback addr %0d", a), v, model[a]);
    end

    write_reg(7'd0, 16'h1234);
    chk("R8 kick on addr 0 write", kick_cnt, exp_kick);
    read_reg(7'd0, v); chk("R2 readback addr 0", v, 16'h1234);

    a = 7'd40;
    read_reg(a, v);
    read_reg(a, v); chk("R5 read leaves register", v, model[a]);

    send({8'h0, 1'b1, 7'd1, 16'h0}, 24);
    ser_le = 1'b0;
    for (int i = 0; i < 16; i++) begin
      repeat (HALF) @(posedge clk); #1;
      chk($sformatf("R5 bit %0d after %0d falls", 15 - i, i), mux_pin, model[1][15-i]);
      ser_clk = 1'b1; repeat (HALF) @(posedge clk); #1 ser_clk = 1'b0;
    end
    repeat (HALF) @(posedge clk); #1;
    chk("R5 zero after 16 falls", mux_pin, 0);
    ser_le = 1'b1; repeat (2*HALF) @(posedge clk); #1;
    tb_sr = '0;
    apply_frame();
    chk("R8 tail frame write addr 0", kick_cnt, exp_kick);

    send({6'h0, 2'b11, 1'b0, 7'd99, 16'hC3A5}, 26);
    read_reg(7'd99, v); chk("R7 long frame", v, 16'hC3A5);
    write_reg(7'h0A, 16'hBCDE);
    send(32'h12, 8);
    collect(v); chk("R7 short frame reads addr 0x3C", v, model[7'h3C]);

    write_reg(7'd0, 16'h0001);
    chk("R8 kick on soft reset", kick_cnt, exp_kick);
    repeat (3) @(posedge clk); #1;
    chk("R4 pin cfg restored", mux_pin, 0);
    write_reg(7'd1, 16'h0002);
    read_reg(7'd99, v); chk("R4 addr 99 restored", v, por(99));
    read_reg(7'd0, v);  chk("R4 soft bit cleared", v, por(0));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule